// File: doc/BRIEF.md
# Handled Event Log Queue

This block keeps a short log of fixed-size event records in arrival order. Each record the block accepts gets a nonzero 16-bit handle from a running counter and the value of a free-running time input at the clock edge where it is taken. When an insert arrives while the log is full, the record is discarded. The block counts these losses and keeps the time of the first and of the most recent one.

A host reads the log from the oldest record onward. The read gives a header with flags and overflow statistics, then streams the records one per cycle, and leaves the log unchanged. To release records, the host sends a list of handles. The block compares the list against the queue from the head. Only when every compared handle matches does it remove that many records. A failed clear removes nothing. A clear runs over several cycles: first a compare phase, then a delete phase. While a clear is in progress, inserts are stalled at the input. A pending level output and a one-cycle interrupt request tell the host that records are waiting.

Top module: `evq_top`

## Requirements
- R1: The log holds at most DEPTH (default 8) records. An insert accepted while DEPTH records are held is dropped. The occupancy is unchanged and the overflow count rises by one, saturating at its maximum.
- R2: On a dropped insert, the last-overflow time takes the current time input. The first-overflow time takes it as well, but only when the overflow count was zero before that drop.
- R3: After reset the handle counter is 1. Each stored record takes the counter value and the counter then adds one. When the count wraps to 0 it is advanced again, so handle 0 is never issued.
- R4: Each stored record keeps the time input value present at the clock edge that accepts it.
- R5: `pending` goes high on the edge that stores a record. It goes low on the edge where a removal leaves the log empty. It is low after reset.
- R6: `irq` is high for exactly one cycle, the cycle after an edge that stores a record into an empty log. It is high at no other time.
- R7: A read request taken while `busy` is low brings `rd_hdr_valid` high in the next cycle. At that time `rd_num` = min(`rd_max`, occupancy). In each of the following `rd_num` cycles, `rd_rec_valid` is high and one record appears, oldest first. Reading removes nothing.
- R8: In the read header, `rd_more` is 1 when the log is not empty. `rd_ovf` is 1 when the overflow count is nonzero. The count and both overflow times are reported as held, and they are all zero after a reset or a removal.
- R9: A clear compares handle slot j (bits [j*HDL_W +: HDL_W] of `clr_list`) with the record at position j from the head, for j below min(`clr_num`, occupancy). If any compared slot is 0 or differs, `clr_done` pulses with `clr_ok` = 0 and no record is removed.
- R10: When every compared slot matches, that many records are removed from the head. `clr_done` then pulses with `clr_ok` = 1. Each removal zeroes the overflow count and both overflow times.
- R11: A `clr_num` above the occupancy checks and removes only the held records and succeeds. A `clr_num` above CLR_MAX is treated as CLR_MAX.
- R12: From the edge that takes a clear until `clr_done`, `ins_ready` is low and `busy` is high, so an insert is held at the input and stored after the clear. A clear request wins over a read request in the same cycle. Requests are ignored while `busy` is high.
- R13: A read with `rd_max` = 0 returns `rd_num` = 0 and no records, with the flags and statistics still valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ts_in | input | TS_W | Free-running time value |
| ins_valid | input | 1 | Insert request |
| ins_payload | input | PAY_W | Record payload to insert |
| ins_ready | output | 1 | Low while a clear is in progress |
| rd_req | input | 1 | Read request |
| rd_max | input | CNT_W | Largest number of records to return |
| rd_hdr_valid | output | 1 | Read header valid for one cycle |
| rd_num | output | CNT_W | Number of records that follow |
| rd_more | output | 1 | Log not empty |
| rd_ovf | output | 1 | Overflow count nonzero |
| rd_ovf_cnt | output | OVF_W | Overflow count |
| rd_ovf_first | output | TS_W | Time of first overflow |
| rd_ovf_last | output | TS_W | Time of latest overflow |
| rd_rec_valid | output | 1 | Streamed record valid |
| rd_rec_payload | output | PAY_W | Record payload |
| rd_rec_handle | output | HDL_W | Record handle |
| rd_rec_ts | output | TS_W | Record time |
| clr_req | input | 1 | Clear request |
| clr_num | input | LCNT_W | Number of handles in the list |
| clr_list | input | CLR_MAX*HDL_W | Handle list, slot j at bits [j*HDL_W +: HDL_W] |
| clr_done | output | 1 | Clear finished, one-cycle pulse |
| clr_ok | output | 1 | Clear result, valid with clr_done |
| busy | output | 1 | A read or clear sequence is running |
| pending | output | 1 | Records are held |
| irq | output | 1 | Interrupt request pulse |

## Verification
An insert becomes visible on `pending` and `irq` in the cycle after its accepting edge. A read header appears one cycle after the request, and record i follows i+2 cycles after it. A clear takes up to 2m+2 cycles, where m is the compare length, so the bench waits for the `clr_done` pulse rather than a fixed count. Every check samples on the falling edge of the cycle where the result is due. The bench confirms stored contents by a read after each change, not by looking inside the design.

// File: rtl/evq_pkg.sv
// Package: shared sequencing states for the event log queue.
// Assumes: only the control sequencer uses the state type.
package evq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_CMP  = 2'd2,
        ST_DEL  = 2'd3
    } evq_state_e;

endpackage

// File: rtl/evq_ring.sv
// Module: circular record store holding payload, handle and time per slot.
// Assumes: push is never raised while full, pop never while empty, and
// push and pop are not raised together in practice (both are handled anyway).
// pk_off selects a record by its distance from the oldest one.
module evq_ring #(
    parameter int DEPTH = 8,
    parameter int PAY_W = 32,
    parameter int TS_W  = 32,
    parameter int HDL_W = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [PAY_W-1:0] push_pay,
    input  logic [HDL_W-1:0] push_hdl,
    input  logic [TS_W-1:0]  push_ts,
    input  logic             pop,
    input  logic [CNT_W-1:0] pk_off,
    output logic [CNT_W-1:0] occ,
    output logic             pending,
    output logic [PAY_W-1:0] pk_pay,
    output logic [HDL_W-1:0] pk_hdl,
    output logic [TS_W-1:0]  pk_ts
);

    logic [PTR_W-1:0] head;
    logic [PTR_W-1:0] tail;
    logic [PAY_W-1:0] pay_mem [DEPTH];
    logic [HDL_W-1:0] hdl_mem [DEPTH];
    logic [TS_W-1:0]  ts_mem  [DEPTH];
    logic [CNT_W:0]   pk_sum;
    logic [CNT_W:0]   pk_wrap;
    logic [PTR_W-1:0] pk_idx;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Advance write and read pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
        end else begin
            if (push) tail <= bump(tail);
            if (pop)  head <= bump(head);
        end
    end

    // Track how many records are held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    // Pending level: set by a store, cleared when a removal empties the log.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (push) begin
            pending <= 1'b1;
        end else if (pop && occ == CNT_W'(1)) begin
            pending <= 1'b0;
        end
    end

    // Write the incoming record into the tail slot (storage needs no reset).
    always_ff @(posedge clk) begin
        if (push) begin
            pay_mem[tail] <= push_pay;
            hdl_mem[tail] <= push_hdl;
            ts_mem[tail]  <= push_ts;
        end
    end

    // Locate the slot pk_off positions after the head, modulo DEPTH.
    always_comb begin
        pk_sum  = (CNT_W + 1)'(head) + (CNT_W + 1)'(pk_off);
        pk_wrap = (pk_sum >= (CNT_W + 1)'(DEPTH)) ? pk_sum - (CNT_W + 1)'(DEPTH) : pk_sum;
        pk_idx  = pk_wrap[PTR_W-1:0];
    end

    assign pk_pay = pay_mem[pk_idx];
    assign pk_hdl = hdl_mem[pk_idx];
    assign pk_ts  = ts_mem[pk_idx];

endmodule

// File: rtl/evq_hgen.sv
// Module: handle counter that skips zero on wrap.
// Assumes: adv is raised once per stored record.
module evq_hgen #(
    parameter int HDL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [HDL_W-1:0] cur
);

    logic [HDL_W-1:0] inc;

    assign inc = cur + 1'b1;

    // Start at one; step past zero when the count wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= HDL_W'(1);
        end else if (adv) begin
            cur <= (inc == '0) ? HDL_W'(1) : inc;
        end
    end

endmodule

// File: rtl/evq_ovf.sv
// Module: overflow statistics, a saturating loss count with first and last times.
// Assumes: wipe (a removal) and drop (a lost insert) never coincide; wipe wins.
module evq_ovf #(
    parameter int TS_W  = 32,
    parameter int OVF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drop,
    input  logic             wipe,
    input  logic [TS_W-1:0]  now,
    output logic [OVF_W-1:0] cnt,
    output logic [TS_W-1:0]  t_first,
    output logic [TS_W-1:0]  t_last
);

    // Count losses and stamp them; a removal clears everything.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            cnt     <= '0;
            t_first <= '0;
            t_last  <= '0;
        end else if (drop) begin
            if (cnt == '0) t_first <= now;
            if (cnt != '1) cnt <= cnt + 1'b1;
            t_last <= now;
        end
    end

endmodule

// File: rtl/evq_ctrl.sv
// Module: read streamer and two-phase clear sequencer.
// Assumes: occupancy does not fall during a read, and no insert reaches the
// store while a clear is active (the top drops ins_ready for that).
module evq_ctrl
    import evq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int PAY_W   = 32,
    parameter int TS_W    = 32,
    parameter int HDL_W   = 16,
    parameter int OVF_W   = 16,
    parameter int CLR_MAX = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int LCNT_W = $clog2(CLR_MAX + 1),
    localparam int LI_W   = (CLR_MAX > 1) ? $clog2(CLR_MAX) : 1,
    localparam int CW     = ((CNT_W > LCNT_W) ? CNT_W : LCNT_W) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_req,
    input  logic [CNT_W-1:0]         rd_max,
    input  logic                     clr_req,
    input  logic [LCNT_W-1:0]        clr_num,
    input  logic [CLR_MAX*HDL_W-1:0] clr_list,
    input  logic [CNT_W-1:0]         occ,
    input  logic [PAY_W-1:0]         pk_pay,
    input  logic [HDL_W-1:0]         pk_hdl,
    input  logic [TS_W-1:0]          pk_ts,
    input  logic [OVF_W-1:0]         ovf_cnt,
    input  logic [TS_W-1:0]          ovf_first,
    input  logic [TS_W-1:0]          ovf_last,
    output logic [CNT_W-1:0]         pk_off,
    output logic                     pop,
    output logic                     clr_active,
    output logic                     busy,
    output logic                     rd_hdr_valid,
    output logic [CNT_W-1:0]         rd_num,
    output logic                     rd_more,
    output logic                     rd_ovf,
    output logic [OVF_W-1:0]         rd_ovf_cnt,
    output logic [TS_W-1:0]          rd_ovf_first,
    output logic [TS_W-1:0]          rd_ovf_last,
    output logic                     rd_rec_valid,
    output logic [PAY_W-1:0]         rd_rec_payload,
    output logic [HDL_W-1:0]         rd_rec_handle,
    output logic [TS_W-1:0]          rd_rec_ts,
    output logic                     clr_done,
    output logic                     clr_ok
);

    evq_state_e                st;
    logic [CNT_W-1:0]          k;
    logic [CW-1:0]             j;
    logic [CW-1:0]             del;
    logic [CW-1:0]             ln;
    logic [CLR_MAX*HDL_W-1:0]  lst_q;
    logic [HDL_W-1:0]          lst_h [CLR_MAX];
    logic [CNT_W-1:0]          rd_take;
    logic [CW-1:0]             num_cap;
    logic [HDL_W-1:0]          cur_h;
    logic                      cmp_end;
    logic                      cmp_bad;

    // Split the captured handle list into slots.
    for (genvar g = 0; g < CLR_MAX; g++) begin : g_slot
        assign lst_h[g] = lst_q[g*HDL_W +: HDL_W];
    end

    // Derived request values and compare-phase decisions.
    always_comb begin
        rd_take = (rd_max < occ) ? rd_max : occ;
        num_cap = (CW'(clr_num) > CW'(CLR_MAX)) ? CW'(CLR_MAX) : CW'(clr_num);
        cmp_end = (j >= ln) || (j >= CW'(occ));
        cur_h   = lst_h[j[LI_W-1:0]];
        cmp_bad = (cur_h == '0) || (cur_h != pk_hdl);
    end

    assign clr_active = (st == ST_CMP) || (st == ST_DEL);
    assign busy       = (st != ST_IDLE);
    assign pop        = (st == ST_DEL);
    assign pk_off     = clr_active ? CNT_W'(j) : k;

    // Sequencer: idle, stream records, compare handles, delete from head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= ST_IDLE;
            k            <= '0;
            j            <= '0;
            del          <= '0;
            ln           <= '0;
            lst_q        <= '0;
            rd_hdr_valid <= 1'b0;
            rd_num       <= '0;
            rd_more      <= 1'b0;
            rd_ovf       <= 1'b0;
            rd_ovf_cnt   <= '0;
            rd_ovf_first <= '0;
            rd_ovf_last  <= '0;
            rd_rec_valid <= 1'b0;
            clr_done     <= 1'b0;
            clr_ok       <= 1'b0;
        end else begin
            rd_hdr_valid <= 1'b0;
            rd_rec_valid <= 1'b0;
            clr_done     <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (clr_req) begin
                        lst_q <= clr_list;
                        ln    <= num_cap;
                        j     <= '0;
                        st    <= ST_CMP;
                    end else if (rd_req) begin
                        rd_hdr_valid <= 1'b1;
                        rd_num       <= rd_take;
                        rd_more      <= (occ != '0);
                        rd_ovf       <= (ovf_cnt != '0);
                        rd_ovf_cnt   <= ovf_cnt;
                        rd_ovf_first <= ovf_first;
                        rd_ovf_last  <= ovf_last;
                        k            <= '0;
                        st           <= (rd_take == '0) ? ST_IDLE : ST_READ;
                    end
                end
                ST_READ: begin
                    rd_rec_valid <= 1'b1;
                    k            <= k + 1'b1;
                    if (k + 1'b1 == rd_num) st <= ST_IDLE;
                end
                ST_CMP: begin
                    if (cmp_end) begin
                        if (j == '0) begin
                            clr_done <= 1'b1;
                            clr_ok   <= 1'b1;
                            st       <= ST_IDLE;
                        end else begin
                            del <= j;
                            st  <= ST_DEL;
                        end
                    end else if (cmp_bad) begin
                        clr_done <= 1'b1;
                        clr_ok   <= 1'b0;
                        st       <= ST_IDLE;
                    end else begin
                        j <= j + 1'b1;
                    end
                end
                ST_DEL: begin
                    del <= del - 1'b1;
                    if (del == CW'(1)) begin
                        clr_done <= 1'b1;
                        clr_ok   <= 1'b1;
                        st       <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Register the streamed record (no reset needed; qualified by rd_rec_valid).
    always_ff @(posedge clk) begin
        if (st == ST_READ) begin
            rd_rec_payload <= pk_pay;
            rd_rec_handle  <= pk_hdl;
            rd_rec_ts      <= pk_ts;
        end
    end

endmodule

// File: rtl/evq_top.sv
// Module: handled event log queue top. It stores records with handles and
// times, tracks losses when full, streams reads and runs all-or-nothing clears.
// Assumes: ts_in advances freely; the host keeps ins_valid high until ins_ready.
module evq_top #(
    parameter int DEPTH   = 8,
    parameter int PAY_W   = 32,
    parameter int TS_W    = 32,
    parameter int HDL_W   = 16,
    parameter int OVF_W   = 16,
    parameter int CLR_MAX = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int LCNT_W = $clog2(CLR_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TS_W-1:0]          ts_in,
    input  logic                     ins_valid,
    input  logic [PAY_W-1:0]         ins_payload,
    output logic                     ins_ready,
    input  logic                     rd_req,
    input  logic [CNT_W-1:0]         rd_max,
    output logic                     rd_hdr_valid,
    output logic [CNT_W-1:0]         rd_num,
    output logic                     rd_more,
    output logic                     rd_ovf,
    output logic [OVF_W-1:0]         rd_ovf_cnt,
    output logic [TS_W-1:0]          rd_ovf_first,
    output logic [TS_W-1:0]          rd_ovf_last,
    output logic                     rd_rec_valid,
    output logic [PAY_W-1:0]         rd_rec_payload,
    output logic [HDL_W-1:0]         rd_rec_handle,
    output logic [TS_W-1:0]          rd_rec_ts,
    input  logic                     clr_req,
    input  logic [LCNT_W-1:0]        clr_num,
    input  logic [CLR_MAX*HDL_W-1:0] clr_list,
    output logic                     clr_done,
    output logic                     clr_ok,
    output logic                     busy,
    output logic                     pending,
    output logic                     irq
);

    logic [CNT_W-1:0] occ;
    logic [CNT_W-1:0] pk_off;
    logic [PAY_W-1:0] pk_pay;
    logic [HDL_W-1:0] pk_hdl;
    logic [TS_W-1:0]  pk_ts;
    logic [HDL_W-1:0] cur_hdl;
    logic [OVF_W-1:0] ovf_cnt;
    logic [TS_W-1:0]  ovf_first;
    logic [TS_W-1:0]  ovf_last;
    logic             pop;
    logic             clr_active;
    logic             take;
    logic             push;
    logic             drop;

    assign ins_ready = !clr_active;
    assign take      = ins_valid && ins_ready;
    assign push      = take && (occ != CNT_W'(DEPTH));
    assign drop      = take && (occ == CNT_W'(DEPTH));

    // Interrupt pulse when a store fills an empty log.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= push && (occ == '0);
    end

    evq_ring #(
        .DEPTH(DEPTH), .PAY_W(PAY_W), .TS_W(TS_W), .HDL_W(HDL_W)
    ) u_ring (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_pay(ins_payload), .push_hdl(cur_hdl), .push_ts(ts_in),
        .pop(pop), .pk_off(pk_off),
        .occ(occ), .pending(pending),
        .pk_pay(pk_pay), .pk_hdl(pk_hdl), .pk_ts(pk_ts)
    );

    evq_hgen #(.HDL_W(HDL_W)) u_hgen (
        .clk(clk), .rst_n(rst_n), .adv(push), .cur(cur_hdl)
    );

    evq_ovf #(.TS_W(TS_W), .OVF_W(OVF_W)) u_ovf (
        .clk(clk), .rst_n(rst_n), .drop(drop), .wipe(pop), .now(ts_in),
        .cnt(ovf_cnt), .t_first(ovf_first), .t_last(ovf_last)
    );

    evq_ctrl #(
        .DEPTH(DEPTH), .PAY_W(PAY_W), .TS_W(TS_W), .HDL_W(HDL_W),
        .OVF_W(OVF_W), .CLR_MAX(CLR_MAX)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .rd_max(rd_max),
        .clr_req(clr_req), .clr_num(clr_num), .clr_list(clr_list),
        .occ(occ), .pk_pay(pk_pay), .pk_hdl(pk_hdl), .pk_ts(pk_ts),
        .ovf_cnt(ovf_cnt), .ovf_first(ovf_first), .ovf_last(ovf_last),
        .pk_off(pk_off), .pop(pop), .clr_active(clr_active), .busy(busy),
        .rd_hdr_valid(rd_hdr_valid), .rd_num(rd_num), .rd_more(rd_more),
        .rd_ovf(rd_ovf), .rd_ovf_cnt(rd_ovf_cnt),
        .rd_ovf_first(rd_ovf_first), .rd_ovf_last(rd_ovf_last),
        .rd_rec_valid(rd_rec_valid), .rd_rec_payload(rd_rec_payload),
        .rd_rec_handle(rd_rec_handle), .rd_rec_ts(rd_rec_ts),
        .clr_done(clr_done), .clr_ok(clr_ok)
    );

endmodule

// File: rtl/evq_chk.sv
// Module: property checker for the event log queue, bound into evq_top.
// Assumes: occ and clr_active are the top's internal occupancy and clear flag.
module evq_chk #(
    parameter int DEPTH = 8,
    parameter int HDL_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_valid,
    input logic             ins_ready,
    input logic [CNT_W-1:0] occ,
    input logic             pending,
    input logic             irq,
    input logic             rd_hdr_valid,
    input logic [CNT_W-1:0] rd_num,
    input logic             rd_rec_valid,
    input logic [HDL_W-1:0] rd_rec_handle,
    input logic             clr_done,
    input logic             clr_ok,
    input logic             clr_active
);

    // R1
    occ_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    // R1
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready && occ == CNT_W'(DEPTH)) |=> (occ == CNT_W'(DEPTH)));

    // R3
    handle_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rec_valid |-> (rd_rec_handle != '0));

    // R5
    pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending == (occ != '0));

    // R6
    irq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (occ == CNT_W'(1) && $past(occ) == '0));

    // R7
    hdr_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hdr_valid |-> (rd_num <= occ));

    // R9
    fail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && !clr_ok) |-> $stable(occ));

    // R12
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_active |=> (occ <= $past(occ)));

endmodule

bind evq_top evq_chk #(.DEPTH(DEPTH), .HDL_W(HDL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .occ(occ), .pending(pending), .irq(irq),
    .rd_hdr_valid(rd_hdr_valid), .rd_num(rd_num),
    .rd_rec_valid(rd_rec_valid), .rd_rec_handle(rd_rec_handle),
    .clr_done(clr_done), .clr_ok(clr_ok), .clr_active(clr_active)
);

// File: tb/tb_evq_top.sv
module tb_evq_top;

    localparam int DEPTH   = 8;
    localparam int PAY_W   = 16;
    localparam int TS_W    = 16;
    localparam int HDL_W   = 4;
    localparam int OVF_W   = 8;
    localparam int CLR_MAX = 8;
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int LCNT_W  = $clog2(CLR_MAX + 1);
    localparam int HMOD    = 1 << HDL_W;
    localparam int OSAT    = (1 << OVF_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [TS_W-1:0] ts_in = '0;
    always @(posedge clk) ts_in <= ts_in + 1'b1;

    logic                     ins_valid = 1'b0;
    logic [PAY_W-1:0]         ins_payload = '0;
    logic                     ins_ready;
    logic                     rd_req = 1'b0;
    logic [CNT_W-1:0]         rd_max = '0;
    logic                     rd_hdr_valid;
    logic [CNT_W-1:0]         rd_num;
    logic                     rd_more;
    logic                     rd_ovf;
    logic [OVF_W-1:0]         rd_ovf_cnt;
    logic [TS_W-1:0]          rd_ovf_first;
    logic [TS_W-1:0]          rd_ovf_last;
    logic                     rd_rec_valid;
    logic [PAY_W-1:0]         rd_rec_payload;
    logic [HDL_W-1:0]         rd_rec_handle;
    logic [TS_W-1:0]          rd_rec_ts;
    logic                     clr_req = 1'b0;
    logic [LCNT_W-1:0]        clr_num = '0;
    logic [CLR_MAX*HDL_W-1:0] clr_list = '0;
    logic                     clr_done;
    logic                     clr_ok;
    logic                     busy;
    logic                     pending;
    logic                     irq;

    evq_top #(
        .DEPTH(DEPTH), .PAY_W(PAY_W), .TS_W(TS_W), .HDL_W(HDL_W),
        .OVF_W(OVF_W), .CLR_MAX(CLR_MAX)
    ) dut (.*);

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    // Reference model of the log.
    int m_n = 0;
    int m_hdl [DEPTH];
    int m_ts  [DEPTH];
    int m_pay [DEPTH];
    int nxt_h = 1;
    int o_cnt = 0;
    int o_first = 0;
    int o_last = 0;
    int pay_seed = 100;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic m_remove(input int n);
        for (int r = 0; r < n; r++) begin
            for (int s = 0; s < DEPTH - 1; s++) begin
                m_hdl[s] = m_hdl[s+1];
                m_ts[s]  = m_ts[s+1];
                m_pay[s] = m_pay[s+1];
            end
            m_n--;
        end
        if (n > 0) begin
            o_cnt = 0; o_first = 0; o_last = 0;
        end
    endtask

    task automatic do_insert();
        int t;
        int was;
        @(negedge clk);
        ins_valid = 1'b1;
        ins_payload = PAY_W'(pay_seed);
        while (!ins_ready) @(negedge clk);
        t = int'(ts_in);
        was = m_n;
        @(negedge clk);
        ins_valid = 1'b0;
        if (m_n == DEPTH) begin
            if (o_cnt == 0) o_first = t;
            if (o_cnt < OSAT) o_cnt++;
            o_last = t;
            chk("R1 no irq on drop", irq, 0);
        end else begin
            m_hdl[m_n] = nxt_h;
            m_ts[m_n]  = t;
            m_pay[m_n] = pay_seed & ((1 << PAY_W) - 1);
            m_n++;
            nxt_h = (nxt_h + 1) % HMOD;
            if (nxt_h == 0) nxt_h = 1;
            chk("R6 irq", irq, (was == 0) ? 1 : 0);
            chk("R5 pending after insert", pending, 1);
        end
        pay_seed = pay_seed + 37;
    endtask

    task automatic do_read(input int mx);
        int en;
        string tag;
        tag = (mx == 0) ? "R13" : "R7";
        en = (mx < m_n) ? mx : m_n;
        @(negedge clk);
        rd_req = 1'b1;
        rd_max = CNT_W'(mx);
        @(negedge clk);
        rd_req = 1'b0;
        chk({tag, " header valid"}, rd_hdr_valid, 1);
        chk({tag, " rd_num"}, rd_num, en);
        chk("R8 more flag", rd_more, (m_n != 0) ? 1 : 0);
        chk("R8 ovf flag", rd_ovf, (o_cnt != 0) ? 1 : 0);
        chk("R8 ovf count", rd_ovf_cnt, o_cnt);
        chk("R2 first ovf time", rd_ovf_first, o_first);
        chk("R2 last ovf time", rd_ovf_last, o_last);
        for (int i = 0; i < en; i++) begin
            @(negedge clk);
            chk("R7 record valid", rd_rec_valid, 1);
            chk("R3 handle", rd_rec_handle, m_hdl[i]);
            chk("R7 payload", rd_rec_payload, m_pay[i]);
            chk("R4 record time", rd_rec_ts, m_ts[i]);
        end
        @(negedge clk);
        chk({tag, " stream ended"}, rd_rec_valid, 0);
        chk({tag, " idle after read"}, busy, 0);
    endtask

    task automatic do_clear(input int n, input int lst [CLR_MAX]);
        int lim;
        int ok;
        int wt;
        int nn;
        nn = (n > CLR_MAX) ? CLR_MAX : n;
        lim = (nn < m_n) ? nn : m_n;
        ok = 1;
        for (int j = 0; j < lim; j++)
            if (lst[j] == 0 || lst[j] != m_hdl[j]) ok = 0;
        @(negedge clk);
        clr_req = 1'b1;
        clr_num = LCNT_W'(n);
        for (int j = 0; j < CLR_MAX; j++) clr_list[j*HDL_W +: HDL_W] = HDL_W'(lst[j]);
        @(negedge clk);
        clr_req = 1'b0;
        wt = 0;
        while (!clr_done && wt < 100) begin
            @(negedge clk);
            wt++;
        end
        chk("R10 clear done", clr_done, 1);
        chk((ok != 0) ? "R10 clear ok" : "R9 clear rejected", clr_ok, ok);
        if (ok != 0) m_remove(lim);
        chk("R5 pending after clear", pending, (m_n != 0) ? 1 : 0);
    endtask

    task automatic good_list(output int lst [CLR_MAX], input int fill_extra);
        for (int j = 0; j < CLR_MAX; j++) lst[j] = (j < m_n) ? m_hdl[j] : fill_extra;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lst [CLR_MAX];
        int t;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 pending at reset", pending, 0);
        chk("R6 irq at reset", irq, 0);
        chk("R12 busy at reset", busy, 0);
        chk("R12 ready at reset", ins_ready, 1);

        // Sweep every fill level and every read size, then clear a long list (R11).
        for (int f = 0; f <= DEPTH; f++) begin
            for (int i = 0; i < f; i++) do_insert();
            for (int mx = 0; mx <= DEPTH + 2; mx++) do_read(mx);
            good_list(lst, 5);
            do_clear((f + 1 > CLR_MAX) ? CLR_MAX : f + 1, lst);
            do_read(DEPTH);
        end

        // Overflow with first/last times (R1, R2).
        for (int i = 0; i < DEPTH + 3; i++) do_insert();
        do_read(DEPTH + 2);

        // Zero handle at slot 0: rejected, nothing removed (R9).
        good_list(lst, 0);
        lst[0] = 0;
        do_clear(3, lst);
        do_read(DEPTH);

        // Mismatch at slot 2: rejected (R9).
        good_list(lst, 0);
        lst[2] = (lst[2] % (HMOD - 1)) + 1;
        do_clear(4, lst);
        do_read(DEPTH);

        // Partial good clear wipes the overflow record (R10).
        good_list(lst, 0);
        do_clear(3, lst);
        do_read(DEPTH);

        // Insert held off during a clear, stored after it (R12).
        good_list(lst, 0);
        @(negedge clk);
        clr_req = 1'b1;
        clr_num = LCNT_W'(2);
        for (int j = 0; j < CLR_MAX; j++) clr_list[j*HDL_W +: HDL_W] = HDL_W'(lst[j]);
        @(negedge clk);
        clr_req = 1'b0;
        ins_valid = 1'b1;
        ins_payload = PAY_W'(pay_seed);
        chk("R12 ready low while clearing", ins_ready, 0);
        chk("R12 busy while clearing", busy, 1);
        t = 0;
        while (!clr_done && t < 100) begin
            @(negedge clk);
            if (!clr_done) chk("R12 ready stays low", ins_ready, 0);
            t++;
        end
        chk("R12 clear ok", clr_ok, 1);
        m_remove(2);
        chk("R12 ready after clear", ins_ready, 1);
        t = int'(ts_in);
        @(negedge clk);
        ins_valid = 1'b0;
        m_hdl[m_n] = nxt_h;
        m_ts[m_n] = t;
        m_pay[m_n] = pay_seed & ((1 << PAY_W) - 1);
        m_n++;
        nxt_h = (nxt_h + 1) % HMOD;
        if (nxt_h == 0) nxt_h = 1;
        pay_seed = pay_seed + 37;
        do_read(DEPTH);

        // Empty list, then drain and clear an empty log (R11).
        good_list(lst, 0);
        do_clear(0, lst);
        good_list(lst, 9);
        do_clear(CLR_MAX, lst);
        good_list(lst, 9);
        do_clear(CLR_MAX, lst);
        do_read(3);

        done_flag = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule